// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recent virtual-page to physical-frame translations. A lookup presents a virtual page number. The block compares that number against every valid entry at once. In the same cycle it either returns the stored frame number or signals a miss.

After a miss, the surrounding logic obtains the frame from the in-memory page table. It then installs the pair through the fill port. A fill lands in one of three places:
- the entry that already holds the same page, if there is one;
- otherwise the lowest-numbered unused entry;
- otherwise the entry named by a round-robin replacement pointer.

A flush input drops every translation at once.

The lookup and fill ports follow valid/ready rules. A lookup is accepted only in a cycle where `lk_valid` and `lk_ready` are both high, and only then does it produce `lk_hit` or `lk_miss`. The block lowers `lk_ready` while a fill is offered or a flush is asserted, so the requester must hold its request until it is accepted. A fill is taken when `fill_valid` and `fill_ready` are both high. `fill_ready` drops only during a flush.

Top module: `xlat_cache`

## Requirements
- R1: An accepted lookup whose page number matches a valid entry raises `lk_hit` in the same cycle and drives that entry's frame number on `lk_pfn`.
- R2: An accepted lookup with no valid matching entry raises `lk_miss` with `lk_pfn` zero. `lk_hit` and `lk_miss` are never high together, and both are low when no lookup is accepted.
- R3: After reset every entry is unused, and an unused entry never produces a hit.
- R4: A fill for a page that is not present goes to the lowest-numbered unused entry while one exists. The replacement pointer does not move.
- R5: When all entries are in use, a fill for a new page replaces the entry at the replacement pointer. The pointer starts at entry 0 and moves on by one per replacement, wrapping after the last entry.
- R6: A fill for a page already present overwrites that entry's frame, never creates a second entry for the page, and leaves the pointer unchanged.
- R7: A flush clears every entry in one cycle and returns the pointer to entry 0. A flush takes priority over a fill in the same cycle: `fill_ready` is low and the fill is dropped.
- R8: While `fill_valid` or `flush` is high, `lk_ready` is low and no lookup result is produced, so a fill has priority over a lookup.
- R9: A fill accepted at a clock edge is visible to a lookup in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request offered |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Accepted lookup found a translation |
| lk_miss | output | 1 | Accepted lookup found no translation |
| lk_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| fill_valid | input | 1 | Translation to install offered |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_pfn | input | PFN_W | Frame number to install |

## Verification
The assertions assume that reset is applied before the first request, and that inputs carry known values at each rising edge. They also assume that entries enter the array only through the fill port. Under those conditions the uniqueness check on matches holds, because a refill of a present page must reuse its entry.

The stimulus drives every input at the falling edge and stays within these conditions. It draws page numbers from a small pool, so that repeat fills of present pages and evictions happen often. It mixes in fills offered with lookups and flushes offered with fills, which exercises the priority rules.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  // Where a fill is steered
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_SAME  = 2'd1,
    TGT_FREE  = 2'd2,
    TGT_EVICT = 2'd3
  } fill_tgt_e;
endpackage

// File: rtl/xlat_cache_cam.sv
module xlat_cache_cam #(
  parameter int N  = 8,
  parameter int VW = 20
) (
  input  logic [VW-1:0]        key,
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][VW-1:0] tags,
  output logic [N-1:0]         match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_cache_store.sv
module xlat_cache_store #(
  parameter int N  = 8,
  parameter int VW = 20,
  parameter int PW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [VW-1:0]        wr_vpn,
  input  logic [PW-1:0]        wr_pfn,
  output logic [N-1:0]         valid,
  output logic [N-1:0][VW-1:0] tags,
  output logic [N-1:0][PW-1:0] pfns
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid <= '0;
    else if (flush)  valid <= '0;
    else if (wr_en)  valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tags[wr_idx] <= wr_vpn;
      pfns[wr_idx] <= wr_pfn;
    end
  end

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));

  assert_fill_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (valid[$past(wr_idx)] && tags[$past(wr_idx)] == $past(wr_vpn)
                           && pfns[$past(wr_idx)] == $past(wr_pfn)));
endmodule

// File: rtl/xlat_cache_victim.sv
module xlat_cache_victim
  import xlat_cache_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fill_go,
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  same_match,
  output logic [IW-1:0] tgt_idx,
  output fill_tgt_e     tgt_kind
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] same_idx;
  logic [IW-1:0] free_idx;
  logic          any_free;

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < N; i++)
      if (same_match[i]) same_idx = IW'(i);
  end

  // scan downward so the lowest unused index wins
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (!fill_go) begin
      tgt_kind = TGT_NONE;
      tgt_idx  = '0;
    end else if (|same_match) begin
      tgt_kind = TGT_SAME;
      tgt_idx  = same_idx;
    end else if (any_free) begin
      tgt_kind = TGT_FREE;
      tgt_idx  = free_idx;
    end else begin
      tgt_kind = TGT_EVICT;
      tgt_idx  = ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (flush)
      ptr <= '0;
    else if (tgt_kind == TGT_EVICT)
      ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
  end

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= IW'(N - 1));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (tgt_kind == TGT_SAME || tgt_kind == TGT_FREE)) |=> $stable(ptr));

  assert_same_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(same_match));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn
);
  logic [ENTRIES-1:0]            valid;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0][PFN_W-1:0] pfns;
  logic [ENTRIES-1:0]            match_lk;
  logic [ENTRIES-1:0]            match_fill;
  logic [IW-1:0]                 tgt_idx;
  fill_tgt_e                     tgt_kind;
  logic                          lk_go;
  logic                          fill_go;
  logic [PFN_W-1:0]              pfn_sel;

  assign fill_ready = !flush;
  assign lk_ready   = !flush && !fill_valid;
  assign fill_go    = fill_valid && fill_ready;
  assign lk_go      = lk_valid && lk_ready;

  xlat_cache_cam #(.N(ENTRIES), .VW(VPN_W)) u_cam_lk (
    .key(lk_vpn), .valid(valid), .tags(tags), .match(match_lk)
  );

  xlat_cache_cam #(.N(ENTRIES), .VW(VPN_W)) u_cam_fill (
    .key(fill_vpn), .valid(valid), .tags(tags), .match(match_fill)
  );

  xlat_cache_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_go(fill_go),
    .valid(valid), .same_match(match_fill),
    .tgt_idx(tgt_idx), .tgt_kind(tgt_kind)
  );

  xlat_cache_store #(.N(ENTRIES), .VW(VPN_W), .PW(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(tgt_kind != TGT_NONE), .wr_idx(tgt_idx),
    .wr_vpn(fill_vpn), .wr_pfn(fill_pfn),
    .valid(valid), .tags(tags), .pfns(pfns)
  );

  always_comb begin
    pfn_sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_lk[i]) pfn_sel |= pfns[i];
  end

  assign lk_hit  = lk_go && (|match_lk);
  assign lk_miss = lk_go && !(|match_lk);
  assign lk_pfn  = lk_hit ? pfn_sel : '0;

  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  assert_fill_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || flush) |-> (!lk_hit && !lk_miss));

  assert_match_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_lk));

  assert_no_hit_after_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lk_hit);

  assert_miss_zero_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pfn == '0));
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;
  localparam int N  = 8;
  localparam int VW = 20;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [VW-1:0] lk_vpn = '0;
  logic          lk_hit;
  logic          lk_miss;
  logic [PW-1:0] lk_pfn;
  logic          fill_valid = 1'b0;
  logic          fill_ready;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // model of the translation array
  logic          m_v   [N];
  logic [VW-1:0] m_tag [N];
  logic [PW-1:0] m_pfn [N];
  int            m_ptr;

  always #5 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW:0] model_find(input logic [VW-1:0] vpn);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_tag[i] == vpn) return {1'b1, m_pfn[i]};
    return '0;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
  endfunction

  function automatic void model_fill(input logic [VW-1:0] vpn, input logic [PW-1:0] pfn);
    int idx;
    idx = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_tag[i] == vpn) idx = i;
    if (idx < 0)
      for (int i = N - 1; i >= 0; i--)
        if (!m_v[i]) idx = i;
    if (idx < 0) begin
      idx = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_v[idx] = 1'b1;
    m_tag[idx] = vpn;
    m_pfn[idx] = pfn;
  endfunction

  // one cycle: drive at falling edge, check just after, update model at rising edge
  task automatic step(input string req, input logic lv, input logic [VW-1:0] lvpn,
                      input logic fv, input logic [VW-1:0] fvpn, input logic [PW-1:0] fpfn,
                      input logic fl);
    logic [PW:0] f;
    logic exp_lr, exp_hit, exp_miss;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn;
    fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn;
    flush = fl;
    #1;
    f = model_find(lvpn);
    exp_lr   = !fl && !fv;
    exp_hit  = lv && exp_lr && f[PW];
    exp_miss = lv && exp_lr && !f[PW];
    chk(req, "lk_ready", 32'(lk_ready), 32'(exp_lr));
    chk(req, "fill_ready", 32'(fill_ready), 32'(!fl));
    chk(req, "lk_hit", 32'(lk_hit), 32'(exp_hit));
    chk(req, "lk_miss", 32'(lk_miss), 32'(exp_miss));
    chk(req, "lk_pfn", 32'(lk_pfn), exp_hit ? 32'(f[PW-1:0]) : 32'd0);
    @(posedge clk);
    if (fl) model_clear();
    else if (fv) model_fill(fvpn, fpfn);
  endtask

  task automatic look(input string req, input logic [VW-1:0] vpn);
    step(req, 1'b1, vpn, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic fill(input string req, input logic [VW-1:0] vpn, input logic [PW-1:0] pfn);
    step(req, 1'b0, '0, 1'b1, vpn, pfn, 1'b0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: empty after reset, every lookup misses
    look("R3", 20'h00000);
    look("R3", 20'h00100);

    // R4 R9 R1: fill all entries, each visible next cycle
    for (int i = 0; i < N; i++) begin
      fill("R4", 20'h00100 + VW'(i), 16'h0040 + PW'(i));
      look("R9", 20'h00100 + VW'(i));
    end
    for (int i = 0; i < N; i++) look("R1", 20'h00100 + VW'(i));

    // R5: replacement starts at entry 0, then entry 1
    fill("R5", 20'h00200, 16'h0AAA);
    look("R5", 20'h00100);
    look("R5", 20'h00101);
    look("R5", 20'h00200);
    fill("R5", 20'h00201, 16'h0BBB);
    look("R5", 20'h00101);
    look("R5", 20'h00102);

    // R6: refill of present page overwrites, pointer stays at entry 2
    fill("R6", 20'h00103, 16'h1234);
    look("R6", 20'h00103);
    fill("R6", 20'h00202, 16'h0CCC);
    look("R6", 20'h00102);
    look("R6", 20'h00103);

    // R8: fill offered with a lookup wins
    step("R8", 1'b1, 20'h00103, 1'b1, 20'h00300, 16'h0DDD, 1'b0);
    look("R8", 20'h00300);

    // R7: flush with fill offered; fill dropped, all entries gone
    step("R7", 1'b1, 20'h00103, 1'b1, 20'h00400, 16'h0EEE, 1'b1);
    look("R7", 20'h00400);
    look("R7", 20'h00103);
    look("R7", 20'h00300);

    // R7 R5: pointer back at entry 0 after flush
    for (int i = 0; i < N; i++) fill("R7", 20'h00500 + VW'(i), PW'(i + 1));
    fill("R7", 20'h00600, 16'h0F00);
    look("R7", 20'h00500);
    look("R7", 20'h00501);

    // R2 and mixed traffic: constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [VW-1:0] a, b;
      r = $urandom_range(0, 99);
      a = 20'h00A00 + VW'($urandom_range(0, 11));
      b = 20'h00A00 + VW'($urandom_range(0, 11));
      if (r < 50)      step("R2", 1'b1, a, 1'b0, '0, '0, 1'b0);
      else if (r < 80) step("R6", 1'b0, '0, 1'b1, b, PW'($urandom), 1'b0);
      else if (r < 88) step("R8", 1'b1, a, 1'b1, b, PW'($urandom), 1'b0);
      else if (r < 92) step("R7", 1'b1, a, 1'b0, '0, '0, 1'b1);
      else if (r < 96) step("R7", 1'b1, a, 1'b1, b, PW'($urandom), 1'b1);
      else             step("R2", 1'b0, a, 1'b0, '0, '0, 1'b0);
    end

    summary();
  end
endmodule